// File: doc/BRIEF.md
# Compare Flags and Branch Decider

This block holds the four condition flags of an 8-bit datapath and turns them into a branch decision. A compare operation subtracts operand B from operand A. A test operation forms the bitwise AND of the two operands. Both operations change only the zero, sign, carry and overflow flags. The arithmetic or logical result is thrown away and never leaves the block. When no operation is selected, the flags keep their values.

A 4-bit condition code then picks one of sixteen conditions. Eight of them read a single flag each. Four give unsigned orderings from carry and zero. Four give signed orderings from sign, overflow and zero. The take-branch output is combinational from the stored flags and the current code. A sequencer can therefore compare in one cycle and decide in the next. Instruction decoding and program counter update live elsewhere.

Top module: `cmp_branch_unit`

## Requirements
- R1: A synchronous active-high reset clears all four flags (Z, S, C, V) to 0.
- R2: Operation select 2'b00 (none) and 2'b11 (reserved) leave every flag unchanged at the clock edge.
- R3: Operation select 2'b01 (compare) sets Z when A-B is zero modulo 2^8, and sets S to bit 7 of A-B.
- R4: On compare, C is the carry out of A + ~B + 1, so C=1 exactly when A >= B as unsigned numbers.
- R5: On compare, V is 1 exactly when A-B overflows as a signed 8-bit subtraction (operand signs differ and the result sign differs from A).
- R6: Operation select 2'b10 (test) sets Z when A&B is zero and sets S to bit 7 of A&B, and clears C and V.
- R7: The flags change only at the rising clock edge that samples the operation; no result of the subtraction or AND is output.
- R8: Single-flag codes: 0 takes when Z=1, 1 when Z=0, 2 when C=1, 3 when C=0, 4 when S=0, 5 when S=1, 6 when V=1, 7 when V=0.
- R9: Unsigned codes after a compare: 8 higher (C & ~Z), 9 higher-or-same (C), 10 lower (~C), 11 lower-or-same (~C | Z).
- R10: Signed codes after a compare: 12 greater (~Z & (S xnor V)), 13 greater-or-equal (S xnor V), 14 less (S xor V), 15 less-or-equal (Z | (S xor V)).
- R11: The take-branch output follows a change of the condition code in the same cycle, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 2 | 00 none, 01 compare, 10 test, 11 reserved (none) |
| opa | input | 8 | Operand A |
| opb | input | 8 | Operand B |
| cond_code | input | 4 | Branch condition select |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored sign flag |
| flag_c | output | 1 | Stored carry flag (no borrow) |
| flag_v | output | 1 | Stored overflow flag |
| take_branch | output | 1 | Branch decision for the selected condition |

## Verification
The bench targets the operand pairs where signed and unsigned orderings disagree. Examples are 0x7F against 0xFF and 0x80 against 0x01. A design that took C as a borrow, or that got overflow wrong, would then pick the wrong side for half of codes 8 to 15. Equal operands check that the strict and non-strict codes split on Z, and that compare sets C rather than clearing it. A test following a compare with C and V set checks that both are cleared. Reserved and idle operation codes check that the flags hold rather than reloading with stale operands.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

  typedef enum logic [1:0] {
    OPS_IDLE = 2'b00,
    OPS_CMP  = 2'b01,
    OPS_TST  = 2'b10,
    OPS_RSV  = 2'b11
  } opsel_t;

  typedef struct packed {
    logic z;
    logic s;
    logic c;
    logic v;
  } ccr_t;

  localparam int unsigned CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    CC_ZSET  = 4'd0,
    CC_ZCLR  = 4'd1,
    CC_CSET  = 4'd2,
    CC_CCLR  = 4'd3,
    CC_SCLR  = 4'd4,
    CC_SSET  = 4'd5,
    CC_VSET  = 4'd6,
    CC_VCLR  = 4'd7,
    CC_UHI   = 4'd8,
    CC_UHS   = 4'd9,
    CC_ULO   = 4'd10,
    CC_ULS   = 4'd11,
    CC_SGT   = 4'd12,
    CC_SGE   = 4'd13,
    CC_SLT   = 4'd14,
    CC_SLE   = 4'd15
  } cond_t;

endpackage

// File: rtl/cbu_flag_calc.sv
module cbu_flag_calc
  import cbu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  opsel_t           op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output ccr_t             nxt,
  output logic             load
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0]   diff_ext;
  logic [WIDTH-1:0] diff;
  logic [WIDTH-1:0] conj;
  ccr_t             cmp_f;
  ccr_t             tst_f;

  // subtract as A + ~B + 1; the extra bit is the carry out
  assign diff_ext = {1'b0, a} + {1'b0, ~b} + {{WIDTH{1'b0}}, 1'b1};
  assign diff     = diff_ext[MSB:0];
  assign conj     = a & b;

  always_comb begin
    cmp_f.z = (diff == '0);
    cmp_f.s = diff[MSB];
    cmp_f.c = diff_ext[WIDTH];
    cmp_f.v = (a[MSB] ^ b[MSB]) & (diff[MSB] ^ a[MSB]);
  end

  always_comb begin
    tst_f.z = (conj == '0);
    tst_f.s = conj[MSB];
    tst_f.c = 1'b0;
    tst_f.v = 1'b0;
  end

  always_comb begin
    nxt  = '0;
    load = 1'b0;
    unique case (op)
      OPS_CMP: begin nxt = cmp_f; load = 1'b1; end
      OPS_TST: begin nxt = tst_f; load = 1'b1; end
      default: begin nxt = '0;    load = 1'b0; end
    endcase
  end
endmodule

// File: rtl/cbu_flag_store.sv
module cbu_flag_store
  import cbu_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  ccr_t nxt,
  output ccr_t cur
);
  always_ff @(posedge clk) begin
    if (rst)       cur <= '0;
    else if (load) cur <= nxt;
  end
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
  import cbu_pkg::*;
(
  input  ccr_t              f,
  input  logic [CODE_W-1:0] code,
  output logic              take
);
  localparam int unsigned NCOND = 1 << CODE_W;

  logic [NCOND-1:0] cond_vec;
  logic             sv_diff;

  assign sv_diff = f.s ^ f.v;

  always_comb begin
    cond_vec          = '0;
    cond_vec[CC_ZSET] = f.z;
    cond_vec[CC_ZCLR] = ~f.z;
    cond_vec[CC_CSET] = f.c;
    cond_vec[CC_CCLR] = ~f.c;
    cond_vec[CC_SCLR] = ~f.s;
    cond_vec[CC_SSET] = f.s;
    cond_vec[CC_VSET] = f.v;
    cond_vec[CC_VCLR] = ~f.v;
    cond_vec[CC_UHI]  = f.c & ~f.z;
    cond_vec[CC_UHS]  = f.c;
    cond_vec[CC_ULO]  = ~f.c;
    cond_vec[CC_ULS]  = ~f.c | f.z;
    cond_vec[CC_SGT]  = ~f.z & ~sv_diff;
    cond_vec[CC_SGE]  = ~sv_diff;
    cond_vec[CC_SLT]  = sv_diff;
    cond_vec[CC_SLE]  = f.z | sv_diff;
  end

  assign take = cond_vec[code];
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       op_sel,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       cond_code,
  output logic             flag_z,
  output logic             flag_s,
  output logic             flag_c,
  output logic             flag_v,
  output logic             take_branch
);
  opsel_t op;
  ccr_t   nxt_f;
  ccr_t   cur_f;
  logic   f_load;

  assign op = opsel_t'(op_sel);

  cbu_flag_calc #(.WIDTH(WIDTH)) u_calc (
    .op   (op),
    .a    (opa),
    .b    (opb),
    .nxt  (nxt_f),
    .load (f_load)
  );

  cbu_flag_store u_store (
    .clk  (clk),
    .rst  (rst),
    .load (f_load),
    .nxt  (nxt_f),
    .cur  (cur_f)
  );

  cbu_cond_eval u_eval (
    .f    (cur_f),
    .code (cond_code),
    .take (take_branch)
  );

  assign flag_z = cur_f.z;
  assign flag_s = cur_f.s;
  assign flag_c = cur_f.c;
  assign flag_v = cur_f.v;
endmodule

// File: rtl/cmp_branch_unit_chk.sv
module cmp_branch_unit_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       op_sel,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [3:0]       cond_code,
  input logic             flag_z,
  input logic             flag_s,
  input logic             flag_c,
  input logic             flag_v,
  input logic             take_branch
);
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!flag_z && !flag_s && !flag_c && !flag_v));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b00 || op_sel == 2'b11) |=>
      ($stable(flag_z) && $stable(flag_s) && $stable(flag_c) && $stable(flag_v)));

  p_cmp_equal_r3: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b01 && opa == opb) |=> (flag_z && flag_c && !flag_v));

  p_cmp_carry_r4: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b01) |=> (flag_c == ($past(opa) >= $past(opb))));

  p_tst_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 2'b10) |=> (!flag_c && !flag_v));

  p_zero_code_r8: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'd0) |-> (take_branch == flag_z));

  p_lt_code_r10: assert property (@(posedge clk) disable iff (rst)
    (cond_code == 4'd14) |-> (take_branch == (flag_s ^ flag_v)));
endmodule

bind cmp_branch_unit cmp_branch_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_sel      (op_sel),
  .opa         (opa),
  .opb         (opb),
  .cond_code   (cond_code),
  .flag_z      (flag_z),
  .flag_s      (flag_s),
  .flag_c      (flag_c),
  .flag_v      (flag_v),
  .take_branch (take_branch)
);

// File: tb/cmp_branch_unit_tb.sv
`timescale 1ns/100ps
module cmp_branch_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op_sel = 2'b00;
  logic [7:0] opa = '0;
  logic [7:0] opb = '0;
  logic [3:0] cond_code = '0;
  logic       flag_z, flag_s, flag_c, flag_v, take_branch;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [3:0] mdl = 4'b0000; // {z,s,c,v}

  always #5 clk = ~clk;

  cmp_branch_unit u_dut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opa(opa), .opb(opb),
    .cond_code(cond_code), .flag_z(flag_z), .flag_s(flag_s),
    .flag_c(flag_c), .flag_v(flag_v), .take_branch(take_branch)
  );

  function automatic logic [3:0] model(input logic [1:0] op, input logic [7:0] a,
                                       input logic [7:0] b, input logic [3:0] old);
    int sa, sb, sd;
    logic [7:0] r;
    if (op == 2'b01) begin
      r  = a - b;
      sa = $signed(a);
      sb = $signed(b);
      sd = sa - sb;
      return {r == 8'd0, r[7], a >= b, (sd > 127) || (sd < -128)};
    end else if (op == 2'b10) begin
      r = a & b;
      return {r == 8'd0, r[7], 1'b0, 1'b0};
    end
    return old;
  endfunction

  function automatic logic want_take(input logic [3:0] f, input logic [3:0] cc);
    logic z, s, c, v;
    {z, s, c, v} = f;
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return !s;
      4'd5:  return s;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return c;
      4'd10: return !c;
      4'd11: return !c || z;
      4'd12: return !z && (s == v);
      4'd13: return s == v;
      4'd14: return s != v;
      default: return z || (s != v);
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] cc);
    if (cc < 4'd8)  return "R8";
    if (cc < 4'd12) return "R9";
    return "R10";
  endfunction

  // R7/R3-R6: apply op for one edge, then check flags and all codes
  task automatic run_op(input logic [1:0] op, input logic [7:0] a, input logic [7:0] b,
                        input string req);
    @(negedge clk);
    op_sel = op; opa = a; opb = b;
    #1;
    check("R7", {4'b0, flag_z, flag_s, flag_c, flag_v}, {4'b0, mdl});
    @(negedge clk);
    mdl = model(op, a, b, mdl);
    op_sel = 2'b00; opa = $urandom; opb = $urandom;
    #1;
    check(req, {4'b0, flag_z, flag_s, flag_c, flag_v}, {4'b0, mdl});
    // R11: decision follows the code with no clock edge in between
    for (int k = 0; k < 16; k++) begin
      cond_code = k[3:0];
      #0.2;
      check(req_of(k[3:0]), {7'b0, take_branch}, {7'b0, want_take(mdl, k[3:0])});
    end
    check("R11", {7'b0, take_branch}, {7'b0, want_take(mdl, 4'd15)});
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {4'b0, flag_z, flag_s, flag_c, flag_v}, 8'h00);
    cond_code = 4'd1;
    #1 check("R1", {7'b0, take_branch}, 8'h01);
    rst = 1'b0;

    run_op(2'b01, 8'h55, 8'h55, "R3");
    run_op(2'b01, 8'h80, 8'h01, "R5");
    run_op(2'b01, 8'h7F, 8'hFF, "R5");
    run_op(2'b01, 8'h00, 8'h01, "R4");
    run_op(2'b01, 8'hFF, 8'h00, "R4");
    run_op(2'b11, 8'h00, 8'h00, "R2");
    run_op(2'b00, 8'h12, 8'h12, "R2");
    run_op(2'b10, 8'hF0, 8'h0F, "R6");
    run_op(2'b01, 8'h7F, 8'hFF, "R5");
    run_op(2'b10, 8'h80, 8'hFF, "R6");
    run_op(2'b01, 8'h01, 8'h80, "R5");
    for (int i = 0; i < 300; i++) begin
      logic [1:0] op;
      logic [7:0] a, b;
      op = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) != 0) op = 2'b01;
      a = $urandom;
      b = ($urandom_range(0, 7) == 0) ? a : 8'($urandom);
      run_op(op, a, b, (op == 2'b01) ? "R3" : (op == 2'b10) ? "R6" : "R2");
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mdl = 4'b0000;
    #1 check("R1", {4'b0, flag_z, flag_s, flag_c, flag_v}, 8'h00);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule